// File: doc/BRIEF.md
# Bank-Mapped Address Translator

This block turns a 16-bit logical processor address into a 21-bit physical address. The logical space is cut into eight 8 KiB pages. Each page has its own mapping register that holds an 8-bit bank number. The physical address is the chosen bank number placed above the 13-bit in-page offset. The top three logical address bits pick the mapping register.

The processor moves bytes between its accumulator and the mapping registers through two mask-driven operations:

- **Write:** one byte is loaded into every register whose mask bit is set, in a single cycle.
- **Read:** the data byte of the highest-indexed selected register is latched into a held output.

Two short access classes give a fixed window into logical space:

- **Direct-page:** offsets land at logical 0x2000.
- **Stack:** offsets land in the 256 bytes that follow it.

Both classes resolve through the mapping register of that page.

Top module: `bank_xlat`

## Requirements
- R1: After reset all eight mapping registers hold 0x00 and `rd_data` is 0x00, so any normal access translates to {0x00, offset}.
- R2: When `acc_kind` is 2'b00 or 2'b11 (normal), `phys_addr` = {bank[log_addr[15:13]], log_addr[12:0]}, combinationally.
- R3: With `wr_en` high, every register whose bit i is set in `wr_mask` is loaded with `wr_data` at the clock edge. Registers whose mask bit is clear keep their value.
- R4: A write becomes visible in translation only after the clock edge. In the cycle of the write, `phys_addr` uses the old bank number.
- R5: With `rd_en` high and a nonzero `rd_mask`, `rd_data` takes, at the clock edge, the contents of the selected register with the highest index.
- R6: `rd_data` keeps its value when `rd_en` is low, or when `rd_en` is high with an all-zero `rd_mask`.
- R7: When `acc_kind` is 2'b01 (direct-page), the access maps to logical 0x2000 | log_addr[7:0]. The result is `phys_addr` = {bank[1], 5'h00, log_addr[7:0]}.
- R8: When `acc_kind` is 2'b10 (stack), the access maps to logical 0x2100 | log_addr[7:0]. The result is `phys_addr` = {bank[1], 5'h01, log_addr[7:0]}.
- R9: A read in the same cycle as a write to the same register returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| log_addr | input | 16 | Logical address |
| acc_kind | input | 2 | Access class: 00/11 normal, 01 direct-page, 10 stack |
| phys_addr | output | 21 | Translated physical address |
| wr_en | input | 1 | Mapping register write strobe |
| wr_mask | input | 8 | Registers to load, one bit per register |
| wr_data | input | 8 | Bank number to load |
| rd_en | input | 1 | Mapping register read strobe |
| rd_mask | input | 8 | Registers to read, one bit per register |
| rd_data | output | 8 | Held read result |

## Verification
The assertions assume that `acc_kind`, `log_addr` and the write inputs are steady over the whole cycle in which they are sampled. They also assume that the direct-page base is aligned so that its stack page stays inside one 8 KiB page. The stimulus changes every input only on the falling clock edge and keeps the default base of 0x2000, which sits at the start of page 1. Read masks cover single bits, several bits, all bits and zero. `rd_en` is also held low while the mask is nonzero, so that the hold rule is exercised from both sides.

// File: rtl/bank_xlat.sv
module bank_xlat #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 13,
  parameter int BANK_W = 8,
  parameter logic [15:0] DP_BASE = 16'h2000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          log_addr,
  input  logic [1:0]                 acc_kind,
  output logic [BANK_W+PAGE_W-1:0]   phys_addr,
  input  logic                       wr_en,
  input  logic [(1<<(ADDR_W-PAGE_W))-1:0] wr_mask,
  input  logic [BANK_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [(1<<(ADDR_W-PAGE_W))-1:0] rd_mask,
  output logic [BANK_W-1:0]          rd_data
);
  localparam int SEL_W = ADDR_W - PAGE_W;
  localparam int NREG  = 1 << SEL_W;
  localparam logic [ADDR_W-1:0] DP_LOG = ADDR_W'(DP_BASE);
  localparam logic [ADDR_W-1:0] SP_LOG = ADDR_W'(DP_BASE) + ADDR_W'(256);

  logic [BANK_W-1:0] bank_q [NREG];
  logic [ADDR_W-1:0] eff_addr;
  logic [BANK_W-1:0] rd_pick;

  always_comb begin
    case (acc_kind)
      2'b01:   eff_addr = DP_LOG | {{(ADDR_W-8){1'b0}}, log_addr[7:0]};
      2'b10:   eff_addr = SP_LOG | {{(ADDR_W-8){1'b0}}, log_addr[7:0]};
      default: eff_addr = log_addr;
    endcase
  end

  assign phys_addr = {bank_q[eff_addr[ADDR_W-1:PAGE_W]], eff_addr[PAGE_W-1:0]};

  always_comb begin
    rd_pick = rd_data;
    for (int i = 0; i < NREG; i++)
      if (rd_mask[i]) rd_pick = bank_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
      rd_data <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_en && wr_mask[i]) bank_q[i] <= wr_data;
      if (rd_en) rd_data <= rd_pick;
    end
  end
endmodule

module bank_xlat_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 13,
  parameter int BANK_W = 8,
  parameter logic [15:0] DP_BASE = 16'h2000
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          log_addr,
  input logic [1:0]                 acc_kind,
  input logic [BANK_W+PAGE_W-1:0]   phys_addr,
  input logic                       wr_en,
  input logic [(1<<(ADDR_W-PAGE_W))-1:0] wr_mask,
  input logic [BANK_W-1:0]          wr_data,
  input logic                       rd_en,
  input logic [(1<<(ADDR_W-PAGE_W))-1:0] rd_mask,
  input logic [BANK_W-1:0]          rd_data
);
  localparam int SEL_W = ADDR_W - PAGE_W;
  localparam int NREG  = 1 << SEL_W;
  localparam logic [PAGE_W-1:0] DP_OFF = DP_BASE[PAGE_W-1:0];
  localparam logic [PAGE_W-1:0] SP_OFF = DP_BASE[PAGE_W-1:0] + PAGE_W'(256);

  assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b00 || acc_kind == 2'b11) |-> phys_addr[PAGE_W-1:0] == log_addr[PAGE_W-1:0]);

  assert_dp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 2'b01 |-> phys_addr[PAGE_W-1:0] == (DP_OFF | PAGE_W'(log_addr[7:0])));

  assert_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 2'b10 |-> phys_addr[PAGE_W-1:0] == (SP_OFF | PAGE_W'(log_addr[7:0])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || rd_mask == '0) |=> $stable(rd_data));

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    assert_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mask[g]) |=>
        (!(acc_kind == 2'b00 && log_addr[ADDR_W-1:PAGE_W] == SEL_W'(g)) ||
         phys_addr[BANK_W+PAGE_W-1:PAGE_W] == $past(wr_data)));
  end
endmodule

bind bank_xlat bank_xlat_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .DP_BASE(DP_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .acc_kind(acc_kind),
  .phys_addr(phys_addr), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
  .rd_en(rd_en), .rd_mask(rd_mask), .rd_data(rd_data)
);

// File: tb/sim_bank_xlat.sv
module sim_bank_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] log_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [20:0] phys_addr;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_mask = '0, wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_mask = '0;
  logic [7:0]  rd_data;

  bank_xlat u0 (.clk(clk), .rst_n(rst_n), .log_addr(log_addr), .acc_kind(acc_kind),
    .phys_addr(phys_addr), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .rd_en(rd_en), .rd_mask(rd_mask), .rd_data(rd_data));

  always #10 clk = ~clk;

  typedef struct { string tag; logic [20:0] val; } item_t;
  item_t phys_q[$];
  item_t rd_q[$];
  int checks = 0, fails = 0;
  logic [7:0] mdl [8];
  logic [7:0] rd_mdl = '0;
  bit done = 0;

  task automatic step(input string tag, input logic [15:0] a, input logic [1:0] k,
                      input logic we, input logic [7:0] wm, input logic [7:0] wd,
                      input logic re, input logic [7:0] rm);
    item_t it;
    @(negedge clk);
    log_addr = a; acc_kind = k; wr_en = we; wr_mask = wm; wr_data = wd;
    rd_en = re; rd_mask = rm;
    it.tag = tag;
    case (k)
      2'b01:   it.val = {mdl[1], 5'h00, a[7:0]};
      2'b10:   it.val = {mdl[1], 5'h01, a[7:0]};
      default: it.val = {mdl[a[15:13]], a[12:0]};
    endcase
    phys_q.push_back(it);
    if (re) for (int i = 0; i < 8; i++) if (rm[i]) rd_mdl = mdl[i];
    it.val = {13'd0, rd_mdl};
    rd_q.push_back(it);
    if (we) for (int i = 0; i < 8; i++) if (wm[i]) mdl[i] = wd;
  endtask

  initial forever begin
    item_t it;
    @(negedge clk); #5;
    if (phys_q.size() > 0) begin
      it = phys_q.pop_front();
      checks++;
      if (phys_addr !== it.val) begin
        fails++;
        $display("FAIL %s phys_addr actual %h expected %h", it.tag, phys_addr, it.val);
      end
    end
  end

  initial forever begin
    item_t it;
    @(posedge clk); #2;
    if (rd_q.size() > 0) begin
      it = rd_q.pop_front();
      checks++;
      if ({13'd0, rd_data} !== it.val) begin
        fails++;
        $display("FAIL %s rd_data actual %h expected %h", it.tag, rd_data, it.val[7:0]);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step("R1", 16'hE123, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R1", 16'h1FFF, 2'b00, 0, 8'h00, 8'h00, 1, 8'h00);
    // R4: write visible only after the edge
    step("R4", 16'hE000, 2'b00, 1, 8'h80, 8'h3C, 0, 8'h00);
    step("R2", 16'hE005, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    // R3: broadcast to pages 1 and 2
    step("R3", 16'h2000, 2'b00, 1, 8'h06, 8'hA5, 0, 8'h00);
    step("R3", 16'h2ABC, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R3", 16'h5ABC, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R3", 16'h0ABC, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R3", 16'hFFFF, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    // distinct banks per page
    for (int i = 0; i < 8; i++)
      step("R3", 16'h0000, 2'b00, 1, 8'(1 << i), 8'(8'h10 + 8'(i) * 8'h11), 0, 8'h00);
    // R2: sweep all pages, kind 11 as normal too
    for (int i = 0; i < 8; i++)
      step("R2", {3'(i), 13'h1234}, (i % 2 == 0) ? 2'b00 : 2'b11, 0, 8'h00, 8'h00, 0, 8'h00);
    // R5: highest selected index wins
    step("R5", 16'h0000, 2'b00, 0, 8'h00, 8'h00, 1, 8'h05);
    step("R5", 16'h0000, 2'b00, 0, 8'h00, 8'h00, 1, 8'hFF);
    step("R5", 16'h0000, 2'b00, 0, 8'h00, 8'h00, 1, 8'h08);
    // R6: hold on zero mask and on rd_en low
    step("R6", 16'h0000, 2'b00, 0, 8'h00, 8'h00, 1, 8'h00);
    step("R6", 16'h0000, 2'b00, 0, 8'h00, 8'h00, 0, 8'h40);
    step("R6", 16'h0000, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    // R9: simultaneous read and write of register 4
    step("R9", 16'h8000, 2'b00, 1, 8'h10, 8'h77, 1, 8'h10);
    step("R9", 16'h8001, 2'b00, 0, 8'h00, 8'h00, 1, 8'h10);
    // R7 / R8: direct-page and stack windows through register 1
    step("R7", 16'hFF42, 2'b01, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R8", 16'h00FF, 2'b10, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R7", 16'h0000, 2'b01, 1, 8'h02, 8'hC3, 0, 8'h00);
    step("R7", 16'h0010, 2'b01, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R8", 16'h1280, 2'b10, 0, 8'h00, 8'h00, 0, 8'h00);
    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0; wr_en = 0; rd_en = 0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    rd_mdl = 8'h00;
    step("R1", 16'hC777, 2'b00, 0, 8'h00, 8'h00, 0, 8'h00);
    step("R1", 16'h0000, 2'b00, 0, 8'h00, 8'h00, 1, 8'hFF);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule